// File: doc/BRIEF.md
# MDIO Station Management Controller

This block is the management-port master of an Ethernet MAC. It carries one clause-22 read or write at a time between the system and an external PHY, over a two-wire management interface: a clock (MDC) and a bidirectional data line (MDIO). Software configures it through three small registers: a control word, a data word and a clock divider.

A transaction starts when the control word is written with its start bit set. The control word holds the PHY address, the register address and the direction. For a write, the value must already be in the data register before the control word is written. For a read, the value returned by the PHY replaces the data register by the time the busy flag drops. MDC runs only while a frame is in flight. Its rate is the system clock divided by twice the divider value plus one.

The MDIO pin is split into three signals: an output value, an output enable and a sampled input. These are meant to be joined in a pad cell outside the block.

Top module: `mdio_master`

## Requirements
- R1: After reset the busy flag reads 0, MDC is low, the MDIO output enable is low, the data register reads 0 and the divider register reads its reset parameter (39 by default).
- R2: Writing register select 0 with bit 0 set, while not busy, starts a frame. The control word layout is PHY address in bits 11:7, register address in bits 6:2, direction in bit 1, and start/busy in bit 0. Bit 0 then reads back as 1 for exactly 130 × (div + 1) system clocks, counted from the write edge, and the address and direction fields read back as written.
- R3: While a frame runs, MDC has a period of 2 × (div + 1) system clocks. Each period has a high half of div + 1 clocks. The divider is register select 2.
- R4: A frame's first 32 bits are all ones. They are followed by the start pattern 0,1 and then the opcode: 0,1 when bit 1 of the control word is 1 (write), or 1,0 when it is 0 (read).
- R5: After the opcode, the 5-bit PHY address and then the 5-bit register address are sent, each most significant bit first.
- R6: In a write, bits 46 and 47 of the frame are driven as 1 then 0. Bits 48 to 63 carry the data register (select 1), most significant bit first. MDIO is driven for all 64 bits, and the data register is left unchanged.
- R7: In a read, the MDIO output enable is low from frame bit 46 to the end of the frame. The 16 data bits are sampled from the MDIO input at each rising edge of MDC for bits 48 to 63, most significant bit first. When busy clears, the data register holds the sampled value.
- R8: While busy, writes to the control, data and divider registers are ignored. A second start neither restarts nor alters the frame in flight, and the control word still reads back the original fields afterwards.
- R9: MDC is low and the output enable is low whenever the block is idle. After bit 63, MDC stays low for one full MDC period before busy clears.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 2 | Write target: 0 control, 1 data, 2 divider |
| regWData | input | 16 | Write value |
| regRdSel | input | 2 | Read-back select (same encoding as regSel) |
| regRdData | output | 16 | Read-back value, combinational |
| mdc | output | 1 | Management clock to the PHY |
| mdioOut | output | 1 | Value driven onto MDIO |
| mdioOe | output | 1 | MDIO output enable; low releases the line |
| mdioIn | input | 1 | Sampled MDIO line |

## Verification
The assertions assume that register writes arrive as single-cycle strobes on the system clock, and that the MDIO input is stable around each rising MDC edge of the read data window. The bench's PHY model changes its data only after each rising MDC edge, so every value it drives is settled well before the next sample. The assertions also assume software never relies on a write landing while busy. The stimulus deliberately issues such writes in the middle of a frame and then checks that neither the wire nor the register contents change.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int BIT_W = 7;

  localparam logic [BIT_W-1:0] PRE_LEN   = 7'd32;
  localparam logic [BIT_W-1:0] TA_POS    = 7'd46;
  localparam logic [BIT_W-1:0] DATA_POS  = 7'd48;
  localparam logic [BIT_W-1:0] FRAME_LEN = 7'd64;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_DIV  = 2'd2;

  typedef struct packed {
    logic load;     // latch a new frame
    logic advance;  // shift frame register at a falling MDC edge
    logic sample;   // capture MDIO at a rising MDC edge
    logic finish;   // frame complete, trailing period over
    logic driveEn;  // controller owns the MDIO line
  } mdioStrobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             opWrite,
  input  logic [DIV_W-1:0] divIn,
  output logic             busy,
  output logic             mdc,
  output logic [BIT_W-1:0] bitIdx,
  output mdioStrobe_t      strobe
);
  logic [DIV_W-1:0] divHold;
  logic [DIV_W-1:0] divCnt;
  logic             phase;
  logic             running;
  logic [BIT_W-1:0] bitCnt;
  logic             halfEnd;
  logic             inFrame;

  assign halfEnd = running && (divCnt == divHold);
  assign inFrame = bitCnt < FRAME_LEN;

  always_comb begin
    strobe.load    = startReq && !running;
    strobe.advance = halfEnd && phase && (bitCnt >= PRE_LEN) && inFrame;
    strobe.sample  = halfEnd && !phase && !opWrite && (bitCnt >= DATA_POS) && inFrame;
    strobe.finish  = halfEnd && phase && (bitCnt == FRAME_LEN);
    strobe.driveEn = running && inFrame && (opWrite || (bitCnt < TA_POS));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      running <= 1'b0;
      phase   <= 1'b0;
      divCnt  <= '0;
      divHold <= '0;
      bitCnt  <= '0;
    end else if (strobe.load) begin
      running <= 1'b1;
      phase   <= 1'b0;
      divCnt  <= '0;
      divHold <= divIn;
      bitCnt  <= '0;
    end else if (running) begin
      if (halfEnd) begin
        divCnt <= '0;
        phase  <= !phase;
        if (phase) begin
          if (bitCnt == FRAME_LEN) running <= 1'b0;
          else                     bitCnt  <= bitCnt + 1'b1;
        end
      end else begin
        divCnt <= divCnt + 1'b1;
      end
    end
  end

  assign busy   = running;
  assign mdc    = running && phase && inFrame;
  assign bitIdx = bitCnt;
endmodule

// File: rtl/mdio_datapath.sv
module mdio_datapath
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 39
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regSel,
  input  logic [15:0]      regWData,
  input  logic [1:0]       regRdSel,
  output logic [15:0]      regRdData,
  input  mdioStrobe_t      strobe,
  input  logic             busy,
  input  logic [BIT_W-1:0] bitIdx,
  input  logic             mdioIn,
  output logic             startReq,
  output logic             opWrite,
  output logic [DIV_W-1:0] divOut,
  output logic             mdioOut,
  output logic             mdioOe
);
  localparam int SH_W = 32;

  logic [4:0]       phyReg;
  logic [4:0]       regReg;
  logic             opReg;
  logic [15:0]      dataReg;
  logic [DIV_W-1:0] divReg;
  logic [SH_W-1:0]  frameSh;
  logic [15:0]      capSh;
  logic             ctrlWr;
  logic             dataWr;
  logic             divWr;
  logic [SH_W-1:0]  frameNext;

  assign ctrlWr   = regWrEn && (regSel == SEL_CTRL) && !busy;
  assign dataWr   = regWrEn && (regSel == SEL_DATA) && !busy;
  assign divWr    = regWrEn && (regSel == SEL_DIV)  && !busy;
  assign startReq = ctrlWr && regWData[0];

  // start, opcode, phy, reg, turnaround, data: built from the word being written
  assign frameNext = {2'b01,
                      regWData[1] ? 2'b01 : 2'b10,
                      regWData[11:7],
                      regWData[6:2],
                      2'b10,
                      dataReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phyReg  <= '0;
      regReg  <= '0;
      opReg   <= 1'b0;
      dataReg <= '0;
      divReg  <= DIV_W'(DIV_INIT);
      frameSh <= '0;
      capSh   <= '0;
    end else begin
      if (ctrlWr) begin
        phyReg <= regWData[11:7];
        regReg <= regWData[6:2];
        opReg  <= regWData[1];
      end
      if (divWr) divReg <= regWData[DIV_W-1:0];
      if (strobe.load)         frameSh <= frameNext;
      else if (strobe.advance) frameSh <= {frameSh[SH_W-2:0], 1'b0};
      if (strobe.sample) capSh <= {capSh[14:0], mdioIn};
      if (dataWr)                         dataReg <= regWData;
      else if (strobe.finish && !opReg)   dataReg <= capSh;
    end
  end

  always_comb begin
    case (regRdSel)
      SEL_CTRL: regRdData = {4'b0000, phyReg, regReg, opReg, busy};
      SEL_DATA: regRdData = dataReg;
      SEL_DIV:  regRdData = 16'(divReg);
      default:  regRdData = '0;
    endcase
  end

  assign opWrite = opReg;
  assign divOut  = divReg;
  assign mdioOe  = strobe.driveEn;
  assign mdioOut = strobe.driveEn && ((bitIdx < PRE_LEN) ? 1'b1 : frameSh[SH_W-1]);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int DIV_W    = 8,
  parameter int DIV_INIT = 39
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic [1:0]  regSel,
  input  logic [15:0] regWData,
  input  logic [1:0]  regRdSel,
  output logic [15:0] regRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobe_t      strobe;
  logic             busyInt;
  logic             startReq;
  logic             opWriteInt;
  logic [DIV_W-1:0] divVal;
  logic [BIT_W-1:0] bitIdxInt;

  mdio_ctrl #(.DIV_W(DIV_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .opWrite(opWriteInt),
    .divIn(divVal), .busy(busyInt), .mdc(mdc), .bitIdx(bitIdxInt), .strobe(strobe)
  );

  mdio_datapath #(.DIV_W(DIV_W), .DIV_INIT(DIV_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWData(regWData),
    .regRdSel(regRdSel), .regRdData(regRdData), .strobe(strobe), .busy(busyInt),
    .bitIdx(bitIdxInt), .mdioIn(mdioIn), .startReq(startReq), .opWrite(opWriteInt),
    .divOut(divVal), .mdioOut(mdioOut), .mdioOe(mdioOe)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        regWrEn,
  input logic [1:0]  regSel,
  input logic [15:0] regWData,
  input logic        busy,
  input logic        opWrite,
  input logic [6:0]  bitIdx,
  input logic        mdc,
  input logic        mdioOe
);
  p_idle_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  p_trail_low_r9: assert property (@(posedge clk) disable iff (!rstN)
    (busy && bitIdx == 7'd64) |-> (!mdc && !mdioOe));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd0 && regWData[0] && !busy) |=> (busy && bitIdx == 7'd0));

  p_no_restart_r8: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regSel == 2'd0 && busy && bitIdx != 7'd64) |=> (busy && bitIdx >= $past(bitIdx)));

  p_read_release_r7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !opWrite && bitIdx >= 7'd46) |-> !mdioOe);

  p_mdc_in_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> busy);
endmodule

bind mdio_master mdio_master_chk u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWData(regWData),
  .busy(busyInt), .opWrite(opWriteInt), .bitIdx(bitIdxInt), .mdc(mdc), .mdioOe(mdioOe)
);

// File: tb/sim_mdio_master.sv
`timescale 1ns/1ps
module sim_mdio_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [1:0]  regSel = 2'd0;
  logic [15:0] regWData = 16'd0;
  logic [1:0]  regRdSel = 2'd0;
  logic [15:0] regRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  int checks = 0;
  int failures = 0;

  // PHY model state
  int   riseCount = 0;
  int   base = 0;
  logic [15:0] rdVal = 16'd0;
  logic bitVal [64];
  logic bitOe [64];
  time  tRise0, tRise1, tFall0;

  always #2.5 clk = ~clk;

  mdio_master u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWData(regWData),
    .regRdSel(regRdSel), .regRdData(regRdData), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int idxNow;
  assign idxNow = riseCount - base;
  assign mdioIn = (idxNow >= 48 && idxNow < 64) ? rdVal[63 - idxNow] : 1'b1;

  always @(posedge mdc) begin
    if (idxNow >= 0 && idxNow < 64) begin
      bitVal[idxNow] = mdioOut;
      bitOe[idxNow]  = mdioOe;
    end
    if (idxNow == 0) tRise0 = $time;
    if (idxNow == 1) tRise1 = $time;
    riseCount = riseCount + 1;
  end

  always @(negedge mdc) begin
    if (idxNow == 1) tFall0 = $time;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [15:0] v);
    regWrEn = 1'b1; regSel = s; regWData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] s, output logic [15:0] v);
    regRdSel = s;
    #0.5;
    v = regRdData;
  endtask

  function automatic int gather(input int lo, input int n);
    int r = 0;
    for (int i = 0; i < n; i++) r = (r << 1) | int'(bitVal[lo + i]);
    return r;
  endfunction

  task automatic xact(input int div, input bit isWr, input int phy, input int rg,
                      input logic [15:0] val, input bit poke);
    logic [15:0] v;
    int cnt;
    int preOk;
    wr(2'd2, 16'(div));
    if (isWr) wr(2'd1, val);
    else begin wr(2'd1, 16'h0000); rdVal = val; end
    base = riseCount;
    for (int i = 0; i < 64; i++) begin bitVal[i] = 1'bx; bitOe[i] = 1'bx; end
    wr(2'd0, 16'((phy << 7) | (rg << 2) | (int'(isWr) << 1) | 1));
    cnt = 0;
    while (mdc !== 1'b0 || regRdData[0] !== 1'b0 || regRdSel != 2'd0) begin
      regRdSel = 2'd0; #0.5;
      if (regRdData[0] !== 1'b1) break;
      cnt++;
      if (poke && cnt == 40) begin regWrEn = 1'b1; regSel = 2'd0; regWData = 16'h0FFF; end
      if (poke && cnt == 41) begin regSel = 2'd1; regWData = ~val; end
      if (poke && cnt == 42) begin regSel = 2'd2; regWData = 16'd7; end
      if (poke && cnt == 43) regWrEn = 1'b0;
      if (cnt > 20000) break;
      @(negedge clk);
    end
    // R2 / R9: busy window length including trailing period
    check(cnt == 130 * (div + 1), "R2 busy length", cnt, 130 * (div + 1));
    // R3: MDC timing
    check(int'(tRise1 - tRise0) == 10 * (div + 1), "R3 mdc period ns", int'(tRise1 - tRise0), 10 * (div + 1));
    check(int'(tFall0 - tRise0) == 5 * (div + 1), "R3 mdc high ns", int'(tFall0 - tRise0), 5 * (div + 1));
    // R4: preamble, start, opcode
    preOk = 1;
    for (int i = 0; i < 32; i++) if (bitVal[i] !== 1'b1 || bitOe[i] !== 1'b1) preOk = 0;
    check(preOk == 1, "R4 preamble", preOk, 1);
    check(gather(32, 4) == (isWr ? 5 : 6), "R4 start+opcode", gather(32, 4), isWr ? 5 : 6);
    // R5: addresses
    check(gather(36, 5) == phy, "R5 phy address", gather(36, 5), phy);
    check(gather(41, 5) == rg, "R5 reg address", gather(41, 5), rg);
    rd(2'd1, v);
    if (isWr) begin
      preOk = 1;
      for (int i = 32; i < 64; i++) if (bitOe[i] !== 1'b1) preOk = 0;
      check(preOk == 1, "R6 driven throughout", preOk, 1);
      check(gather(46, 2) == 2, "R6 turnaround", gather(46, 2), 2);
      check(gather(48, 16) == int'(val), "R6 write data", gather(48, 16), int'(val));
      check(v == val, "R6 data reg kept", int'(v), int'(val));
    end else begin
      preOk = 1;
      for (int i = 46; i < 64; i++) if (bitOe[i] !== 1'b0) preOk = 0;
      check(preOk == 1, "R7 line released", preOk, 1);
      check(v == val, "R7 read data", int'(v), int'(val));
    end
    // R9: idle state after completion
    check(mdc == 1'b0 && mdioOe == 1'b0, "R9 idle pins", int'({mdc, mdioOe}), 0);
    rd(2'd0, v);
    check(v == 16'((phy << 7) | (rg << 2) | (int'(isWr) << 1)), "R2 ctrl readback", int'(v),
          (phy << 7) | (rg << 2) | (int'(isWr) << 1));
    if (poke) begin
      rd(2'd2, v);
      check(int'(v) == div, "R8 divider untouched", int'(v), div);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    // R1: reset state
    rd(2'd0, v);
    check(v[0] == 1'b0, "R1 busy", int'(v[0]), 0);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R1 pins", int'({mdc, mdioOe}), 0);
    rd(2'd1, v);
    check(v == 16'd0, "R1 data", int'(v), 0);
    rd(2'd2, v);
    check(v == 16'd39, "R1 divider", int'(v), 39);
    rstN = 1'b1;
    @(negedge clk);
    foreach (v[i]) v[i] = 1'b0;
    for (int d = 0; d < 4; d++) begin
      for (int w = 0; w < 2; w++) begin
        for (int p = 0; p < 4; p++) begin
          int dv, phy, rg;
          logic [15:0] pat;
          dv  = (d == 3) ? 4 : d;
          phy = (p == 0) ? 0 : (p == 1) ? 31 : (p * 9 + dv) % 32;
          rg  = (p == 0) ? 31 : (p == 1) ? 0 : (p * 13 + w) % 32;
          pat = (p == 0) ? 16'hFFFF : (p == 1) ? 16'h0000 : 16'(16'hA5C3 ^ (p * 16'h1357) ^ dv);
          xact(dv, w[0], phy, rg, pat, 1'b0);
        end
      end
    end
    // R8: writes during a frame are ignored
    xact(2, 1'b1, 5, 17, 16'h3C5A, 1'b1);
    xact(1, 1'b0, 22, 9, 16'h8001, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule